// File: doc/BRIEF.md
# Thirty-Two Line Register-Mapped GPIO Port

This block is a 32-line general-purpose I/O port that software reaches through a plain 32-bit register bus. The bus has an address, a write strobe, write data and read data. A write takes effect at the clock edge on which `bus_we` is high. A read is combinational from `bus_addr` and reflects the register state after the most recent edge. The bus has no handshake: every access completes in one cycle, so there is no back-pressure.

Each register assigns line n to register bit 31-n. The block holds per-line direction, open-drain and output-data settings and turns them into pad output-enable and pad output-value signals. The pad side is indexed by line number. Pad inputs pass through a synchroniser before they are read or handed on.

The block also keeps an interrupt pending register, an interrupt mask register and two edge-selection registers. A separate edge-detection unit consumes the synchronised inputs, the mask and the edge settings, and reports new events back through `evt_set`. Every signal on the edge-unit side uses register bit order.

A build parameter can make four lines input-only. The default makes lines 28 to 31 input-only. The alternative makes lines 0 to 3 input-only.

Top module: `gpio_regbank`

## Requirements
- R1: After reset every register reads 0, `pad_oe` is all zero, and the pending, mask and edge outputs are all zero.
- R2: Line n corresponds to register bit 31-n in every register. For example, writing data bit 31 affects `pad_out[0]`.
- R3: Direction bit 1 makes a line an output. For a push-pull line (open-drain bit 0), `pad_oe[n]` equals the direction bit. `pad_out[n]` is always the data bit ANDed with the inverted open-drain bit.
- R4: For an output line whose open-drain bit is 1, `pad_oe[n]` is 1 only while its data bit is 0, and `pad_out[n]` is 0.
- R5: A read at offset 0x08 returns `(synced_pads & ~dir) | (data & dir)` in register bit order. Output lines read back the written value, and input lines read back the sampled pad level.
- R6: Input-only lines keep direction bit 0 whatever is written and never assert `pad_oe`. The default input-only lines are 28 to 31, which are register bits 3 to 0.
- R7: Writing to the pending register at offset 0x0C clears each bit written as 1. Bits written as 0 are left as they are.
- R8: Each `evt_set` bit that is high at a clock edge sets the matching pending bit. Setting takes priority over a clear written in the same cycle.
- R9: The mapped offsets are 0x00 direction, 0x04 open-drain, 0x08 data, 0x0C pending, 0x10 mask, 0x14 edge A and 0x18 edge B. Any other address reads 0, and a write to it changes no register.
- R10: The mask and both edge registers read back what was written, and they appear unchanged on `irq_mask`, `edge_cfg_a` and `edge_cfg_b`.
- R11: A change on `pad_in` appears on `in_sync`, and in the data read, after exactly two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| pad_in | input | 32 | Raw pad levels, indexed by line |
| pad_oe | output | 32 | Pad output enables, indexed by line |
| pad_out | output | 32 | Pad output values, indexed by line |
| in_sync | output | 32 | Synchronised pad levels in register order, to the edge unit |
| evt_set | input | 32 | Event set strobes from the edge unit, register order |
| evt_pend | output | 32 | Pending event bits |
| irq_mask | output | 32 | Interrupt mask register |
| edge_cfg_a | output | 32 | First edge-selection register |
| edge_cfg_b | output | 32 | Second edge-selection register |

## Verification
Two functions can act in the same cycle: the edge unit setting a pending bit, and software clearing that same bit by a write of 1 to the pending register. The bench provokes the collision on purpose, driving one `evt_set` bit together with a clearing write to that bit. It then expects the bit to remain set, while other bits in the same write are cleared. A random phase also lets set strobes and pending writes overlap freely. In that phase a behavioural model judges every pending bit on every clock, under the rule that setting wins.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int unsigned PIO_LINES = 32;

  localparam int unsigned OFF_DIR  = 'h00;
  localparam int unsigned OFF_OD   = 'h04;
  localparam int unsigned OFF_DAT  = 'h08;
  localparam int unsigned OFF_EVT  = 'h0C;
  localparam int unsigned OFF_MSK  = 'h10;
  localparam int unsigned OFF_EDGA = 'h14;
  localparam int unsigned OFF_EDGB = 'h18;

  typedef enum logic [1:0] {
    INONLY_NONE = 2'd0,
    INONLY_TOP  = 2'd1,
    INONLY_LOW  = 2'd2
  } inonly_e;

  typedef enum logic [2:0] {
    SEL_DIR, SEL_OD, SEL_DAT, SEL_EVT, SEL_MSK, SEL_EDGA, SEL_EDGB, SEL_NONE
  } reg_sel_e;

  // Swap line order and register bit order (line n <-> bit 31-n).
  function automatic logic [PIO_LINES-1:0] flip_lines(input logic [PIO_LINES-1:0] x);
    logic [PIO_LINES-1:0] r;
    for (int i = 0; i < PIO_LINES; i++) r[i] = x[PIO_LINES-1-i];
    return r;
  endfunction

  // Input-only lines, indexed by line number.
  function automatic logic [PIO_LINES-1:0] ro_line_mask(input inonly_e kind,
                                                        input int unsigned cnt);
    logic [PIO_LINES-1:0] m;
    m = '0;
    for (int n = 0; n < PIO_LINES; n++) begin
      if (kind == INONLY_TOP && n >= int'(PIO_LINES - cnt)) m[n] = 1'b1;
      if (kind == INONLY_LOW && n < int'(cnt))              m[n] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/pio_addr_dec.sv
module pio_addr_dec
  import pio_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  always_comb begin
    if      (addr == ADDR_W'(OFF_DIR))  sel = SEL_DIR;
    else if (addr == ADDR_W'(OFF_OD))   sel = SEL_OD;
    else if (addr == ADDR_W'(OFF_DAT))  sel = SEL_DAT;
    else if (addr == ADDR_W'(OFF_EVT))  sel = SEL_EVT;
    else if (addr == ADDR_W'(OFF_MSK))  sel = SEL_MSK;
    else if (addr == ADDR_W'(OFF_EDGA)) sel = SEL_EDGA;
    else if (addr == ADDR_W'(OFF_EDGB)) sel = SEL_EDGB;
    else                                sel = SEL_NONE;
  end

endmodule

// File: rtl/pio_cfg_regs.sv
module pio_cfg_regs
  import pio_pkg::*;
#(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] DIR_FIXED0 = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  reg_sel_e     sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] od_q,
  output logic [W-1:0] dat_q,
  output logic [W-1:0] msk_q,
  output logic [W-1:0] edga_q,
  output logic [W-1:0] edgb_q
);

  logic [W-1:0] dir_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_raw <= '0;
      od_q    <= '0;
      dat_q   <= '0;
      msk_q   <= '0;
      edga_q  <= '0;
      edgb_q  <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_DIR:  dir_raw <= wdata;
        SEL_OD:   od_q    <= wdata;
        SEL_DAT:  dat_q   <= wdata;
        SEL_MSK:  msk_q   <= wdata;
        SEL_EDGA: edga_q  <= wdata;
        SEL_EDGB: edgb_q  <= wdata;
        default:  ;
      endcase
    end
  end

  // Fixed-input bits are tied off per bit; the flop stays for uniformity.
  for (genvar b = 0; b < W; b++) begin : g_dir
    if (DIR_FIXED0[b]) begin : g_ro
      assign dir_q[b] = 1'b0;
    end else begin : g_rw
      assign dir_q[b] = dir_raw[b];
    end
  end

endmodule

// File: rtl/pio_event_regs.sv
module pio_event_regs #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_i) | set_i;
  end

endmodule

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/pio_pad_drive.sv
module pio_pad_drive #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] dir_r,
  input  logic [W-1:0] od_r,
  input  logic [W-1:0] dat_r,
  output logic [W-1:0] oe_l,
  output logic [W-1:0] out_l
);

  for (genvar n = 0; n < W; n++) begin : g_line
    localparam int unsigned B = W - 1 - n;
    assign oe_l[n]  = dir_r[B] & (~od_r[B] | ~dat_r[B]);
    assign out_l[n] = dat_r[B] & ~od_r[B];
  end

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import pio_pkg::*;
#(
  parameter int unsigned ADDR_W      = 5,
  parameter inonly_e     INONLY_KIND = INONLY_TOP,
  parameter int unsigned INONLY_CNT  = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       pad_in,
  output logic [31:0]       pad_oe,
  output logic [31:0]       pad_out,
  output logic [31:0]       in_sync,
  input  logic [31:0]       evt_set,
  output logic [31:0]       evt_pend,
  output logic [31:0]       irq_mask,
  output logic [31:0]       edge_cfg_a,
  output logic [31:0]       edge_cfg_b
);

  localparam logic [31:0] RO_REG_BITS = flip_lines(ro_line_mask(INONLY_KIND, INONLY_CNT));

  reg_sel_e    sel;
  logic [31:0] dir_q, od_q, dat_q;
  logic [31:0] evt_clr;

  pio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  pio_cfg_regs #(.W(32), .DIR_FIXED0(RO_REG_BITS)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (bus_we),
    .sel    (sel),
    .wdata  (bus_wdata),
    .dir_q  (dir_q),
    .od_q   (od_q),
    .dat_q  (dat_q),
    .msk_q  (irq_mask),
    .edga_q (edge_cfg_a),
    .edgb_q (edge_cfg_b)
  );

  assign evt_clr = (bus_we && sel == SEL_EVT) ? bus_wdata : '0;

  pio_event_regs #(.W(32)) u_evt (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (evt_set),
    .clr_i  (evt_clr),
    .pend_q (evt_pend)
  );

  pio_sync #(.W(32), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (flip_lines(pad_in)),
    .q     (in_sync)
  );

  pio_pad_drive #(.W(32)) u_pad (
    .dir_r (dir_q),
    .od_r  (od_q),
    .dat_r (dat_q),
    .oe_l  (pad_oe),
    .out_l (pad_out)
  );

  always_comb begin
    case (sel)
      SEL_DIR:  bus_rdata = dir_q;
      SEL_OD:   bus_rdata = od_q;
      SEL_DAT:  bus_rdata = (in_sync & ~dir_q) | (dat_q & dir_q);
      SEL_EVT:  bus_rdata = evt_pend;
      SEL_MSK:  bus_rdata = irq_mask;
      SEL_EDGA: bus_rdata = edge_cfg_a;
      SEL_EDGB: bus_rdata = edge_cfg_b;
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk
  import pio_pkg::*;
#(
  parameter int unsigned ADDR_W      = 5,
  parameter inonly_e     INONLY_KIND = INONLY_TOP,
  parameter int unsigned INONLY_CNT  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [31:0]       pad_oe,
  input logic [31:0]       pad_out,
  input logic [31:0]       od_q,
  input logic [31:0]       evt_set,
  input logic [31:0]       evt_pend
);

  localparam logic [31:0] RO_LINES = ro_line_mask(INONLY_KIND, INONLY_CNT);

  logic mapped;
  assign mapped = (bus_addr == ADDR_W'(OFF_DIR))  || (bus_addr == ADDR_W'(OFF_OD))  ||
                  (bus_addr == ADDR_W'(OFF_DAT))  || (bus_addr == ADDR_W'(OFF_EVT)) ||
                  (bus_addr == ADDR_W'(OFF_MSK))  || (bus_addr == ADDR_W'(OFF_EDGA)) ||
                  (bus_addr == ADDR_W'(OFF_EDGB));

  assert_od_no_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_out & flip_lines(od_q)) == 32'h0);

  assert_inonly_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & RO_LINES) == 32'h0);

  assert_evt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFF_EVT)) |=>
      ((evt_pend & $past(bus_wdata) & ~$past(evt_set)) == 32'h0));

  assert_evt_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != 32'h0) |=> ((evt_pend & $past(evt_set)) == $past(evt_set)));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (bus_rdata == 32'h0));

endmodule

bind gpio_regbank gpio_regbank_chk #(
  .ADDR_W(ADDR_W), .INONLY_KIND(INONLY_KIND), .INONLY_CNT(INONLY_CNT)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_oe    (pad_oe),
  .pad_out   (pad_out),
  .od_q      (od_q),
  .evt_set   (evt_set),
  .evt_pend  (evt_pend)
);

// File: tb/gpio_regbank_tb_top.sv
module gpio_regbank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_oe, pad_out, in_sync;
  logic [31:0] evt_set = '0;
  logic [31:0] evt_pend, irq_mask, edge_cfg_a, edge_cfg_b;

  always #10 clk = ~clk;

  gpio_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .in_sync(in_sync), .evt_set(evt_set),
    .evt_pend(evt_pend), .irq_mask(irq_mask), .edge_cfg_a(edge_cfg_a),
    .edge_cfg_b(edge_cfg_b)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] rv(input logic [31:0] x);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = x[31-i];
    return r;
  endfunction

  // Behavioural reference model, register bit order.
  localparam logic [31:0] RO_BITS = 32'h0000_000F;  // lines 28..31
  logic [31:0] m_dir, m_od, m_dat, m_evt, m_msk, m_ea, m_eb;
  logic [31:0] pq[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = 0; m_od = 0; m_dat = 0; m_evt = 0; m_msk = 0; m_ea = 0; m_eb = 0;
      pq.delete(); pq.push_back(32'h0); pq.push_back(32'h0);
    end else begin
      logic [31:0] clr;
      clr = 0;
      if (bus_we) begin
        case (bus_addr)
          5'h00: m_dir = bus_wdata & ~RO_BITS;
          5'h04: m_od  = bus_wdata;
          5'h08: m_dat = bus_wdata;
          5'h0C: clr   = bus_wdata;
          5'h10: m_msk = bus_wdata;
          5'h14: m_ea  = bus_wdata;
          5'h18: m_eb  = bus_wdata;
          default: ;
        endcase
      end
      m_evt = (m_evt & ~clr) | evt_set;
      pq.push_back(rv(pad_in));
      void'(pq.pop_front());
    end
  end

  function automatic logic [31:0] m_read(input logic [4:0] a);
    case (a)
      5'h00: return m_dir;
      5'h04: return m_od;
      5'h08: return (pq[0] & ~m_dir) | (m_dat & m_dir);
      5'h0C: return m_evt;
      5'h10: return m_msk;
      5'h14: return m_ea;
      5'h18: return m_eb;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] m_oe();
    logic [31:0] r;
    for (int n = 0; n < 32; n++) r[n] = m_dir[31-n] & (~m_od[31-n] | ~m_dat[31-n]);
    return r;
  endfunction

  function automatic logic [31:0] m_out();
    logic [31:0] r;
    for (int n = 0; n < 32; n++) r[n] = m_dat[31-n] & ~m_od[31-n];
    return r;
  endfunction

  // Every-clock comparison against the model.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R3 R4 pad_oe per-cycle", pad_oe, m_oe());
      chk("R3 R4 pad_out per-cycle", pad_out, m_out());
      chk("R11 in_sync per-cycle", in_sync, pq[0]);
      chk("R8 evt_pend per-cycle", evt_pend, m_evt);
      chk("R10 irq_mask per-cycle", irq_mask, m_msk);
      chk("R10 edge_cfg_a per-cycle", edge_cfg_a, m_ea);
      chk("R10 edge_cfg_b per-cycle", edge_cfg_b, m_eb);
      chk("R5 R9 bus_rdata per-cycle", bus_rdata, m_read(bus_addr));
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); #2;
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk); #2;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); #2;
    bus_addr = a;
    #3 d = bus_rdata;
  endtask

  logic [31:0] v;

  initial begin
    #4_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 28; a += 4) begin
      rd(5'(a), v); chk("R1 register reset value", v, 32'h0);
    end
    chk("R1 pad_oe after reset", pad_oe, 32'h0);
    chk("R1 evt_pend after reset", evt_pend, 32'h0);

    // R6 input-only direction bits
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h00, v); chk("R6 dir readback drops input-only bits", v, 32'hFFFF_FFF0);
    chk("R6 R3 pad_oe with all outputs push-pull", pad_oe, 32'h0FFF_FFFF);

    // R2 bit order
    wr(5'h08, 32'h8000_0000);
    chk("R2 data bit 31 drives line 0", pad_out, 32'h0000_0001);
    wr(5'h08, 32'h0000_0010);
    chk("R2 data bit 4 drives line 27", pad_out, 32'h0800_0000);

    // R4 open drain
    wr(5'h08, 32'h8000_0001);
    wr(5'h04, 32'h8000_FFFF);
    chk("R4 open-drain line 0 with data 1 releases", pad_oe[0], 1'b0);
    chk("R4 open-drain line 16 with data 0 drives", pad_oe[16], 1'b1);
    chk("R4 open-drain lines present 0", pad_out, 32'h0);
    wr(5'h04, 32'h0);

    // R11 / R5 synchroniser latency
    wr(5'h00, 32'h0);
    @(negedge clk); #2 pad_in = 32'h0000_0001;
    rd(5'h08, v); chk("R11 pad change not visible after one edge", v, 32'h0);
    rd(5'h08, v); chk("R11 pad change visible after two edges", v, 32'h8000_0000);

    // R5 merged readback
    wr(5'h00, 32'hF000_0000);
    wr(5'h08, 32'hA000_0000);
    @(negedge clk); #2 pad_in = 32'hFFFF_FFFF;
    repeat (2) @(negedge clk);
    rd(5'h08, v); chk("R5 outputs from shadow, inputs from pads", v, 32'hAFFF_FFFF);
    @(negedge clk); #2 pad_in = 32'h0;
    repeat (2) @(negedge clk);
    rd(5'h08, v); chk("R5 outputs held while pads low", v, 32'hA000_0000);

    // R8 set, R7 clear
    @(negedge clk); #2 evt_set = 32'h0000_0011;
    @(negedge clk); #2 evt_set = 32'h0;
    chk("R8 event strobe sets pending", evt_pend, 32'h0000_0011);
    wr(5'h0C, 32'h0000_0001);
    chk("R7 write one clears bit", evt_pend, 32'h0000_0010);
    wr(5'h0C, 32'h0);
    chk("R7 write zero leaves bits", evt_pend, 32'h0000_0010);
    @(negedge clk); #2 evt_set = 32'h0000_0100;
    @(negedge clk); #2 evt_set = 32'h0;
    @(negedge clk); #2;
    bus_addr = 5'h0C; bus_we = 1'b1; bus_wdata = 32'h0000_0110; evt_set = 32'h0000_0100;
    @(negedge clk); #2 bus_we = 1'b0; evt_set = 32'h0;
    chk("R8 set wins over same-cycle clear", evt_pend, 32'h0000_0100);
    wr(5'h0C, 32'hFFFF_FFFF);
    chk("R7 clear all", evt_pend, 32'h0);

    // R10 mask and edge registers
    wr(5'h10, 32'h1234_5678);
    wr(5'h14, 32'hCAFE_0001);
    wr(5'h18, 32'h0F0F_A5A5);
    rd(5'h10, v); chk("R10 mask readback", v, 32'h1234_5678);
    chk("R10 mask port", irq_mask, 32'h1234_5678);
    rd(5'h18, v); chk("R10 edge B readback", v, 32'h0F0F_A5A5);

    // R9 unmapped
    wr(5'h1C, 32'hFFFF_FFFF);
    rd(5'h1C, v); chk("R9 unmapped 0x1C reads zero", v, 32'h0);
    wr(5'h02, 32'hFFFF_FFFF);
    rd(5'h02, v); chk("R9 unaligned 0x02 reads zero", v, 32'h0);
    rd(5'h00, v); chk("R9 direction untouched by unmapped write", v, 32'hF000_0000);
    rd(5'h10, v); chk("R9 mask untouched by unmapped write", v, 32'h1234_5678);

    // Random traffic, judged by the per-cycle model compare.
    for (int i = 0; i < 600; i++) begin
      @(negedge clk); #2;
      bus_addr  = 5'($urandom_range(0, 31));
      bus_we    = 1'($urandom_range(0, 1));
      bus_wdata = $urandom;
      pad_in    = $urandom;
      evt_set   = ($urandom_range(0, 3) == 0) ? $urandom : 32'h0;
    end
    @(negedge clk); #2 bus_we = 1'b0; evt_set = 32'h0;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule